// File: doc/BRIEF.md
# Carry-Save Constant Multiplier by 693

This block multiplies a signed two's-complement sample by the fixed odd constant 693. It has no general multiplier. The constant is built from hard-wired shifts feeding a network of 3:2 carry-save compressors, so no carry ripples through the multiplication itself.

The product leaves the compressor network as a redundant sum/carry pair. The pair is registered and exposed at the ports, so a downstream carry-save accumulator can consume it directly. One carry-propagate adder then merges the pair into a plain binary word in a second register stage. A valid flag travels alongside the data. Each data register loads only when its stage receives valid data.

A parameter picks one of two adder networks:

- The signed-digit network sums six shifted terms: +1024x, -256x, -64x, -16x, +4x and +x. It needs four compressors.
- The shared network first forms 21x as a pair. Because 693 = 33 x 21, it then compresses 32 times that pair plus the pair itself, which needs three compressors.

Both networks give the same binary product.

Top module: `cmul693_top`

## Requirements
- R1: One cycle after `pair_vld_o` is high, `prod_o` equals the signed product `x_i * 693`, as a W+10-bit two's-complement value, for every W-bit input including the most negative one.
- R2: `pair_vld_o` is high exactly one clock after a cycle with `in_vld_i` high, and `out_vld_o` is high exactly two clocks after that cycle.
- R3: One clock after an accepted input, `(sum_o + carry_o)` taken modulo 2^(W+10) equals `x_i * 693` in W+10-bit two's complement.
- R4: A cycle with `in_vld_i` low leaves `sum_o` and `carry_o` unchanged. A cycle with `pair_vld_o` low leaves `prod_o` unchanged.
- R5: The two networks give bit-identical `prod_o`: `ARCH = CMUL_CSD` (four compressors, subtracted terms formed by inversion plus +1 carry-ins) and `ARCH = CMUL_SHARED` (three compressors).
- R6: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Input sample valid; also acts as the clock enable of the first stage |
| x_i | input | W | Signed input sample |
| pair_vld_o | output | 1 | Redundant pair valid |
| sum_o | output | W+10 | Registered sum vector of the compressor network |
| carry_o | output | W+10 | Registered carry vector, already weighted |
| out_vld_o | output | 1 | Product valid |
| prod_o | output | W+10 | Registered binary product |

## Verification
The checker tests the following on every cycle against the registered input:

- the redundant pair's value;
- the carry-propagate result against the pair it came from;
- the two-cycle valid latency;
- the hold behaviour of both data stages.

Only the bench's scenarios can show the rest:

- the full sweep of all 4096 12-bit inputs, including -2048;
- agreement between the four-compressor and three-compressor networks, which needs two instances side by side;
- the reset values;
- idle gaps placed inside the sweep.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  localparam int unsigned CMUL_K      = 693;
  localparam int unsigned CMUL_GROWTH = 10;
  typedef enum logic {CMUL_CSD = 1'b0, CMUL_SHARED = 1'b1} cmul_arch_e;
endpackage

// File: rtl/cmul_csa3.sv
module cmul_csa3 #(
  parameter int WIDTH = 22
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] s_o,
  output logic [WIDTH-1:0] cy_o
);
  logic [WIDTH-2:0] maj;
  assign s_o = a_i ^ b_i ^ c_i;
  assign maj = (a_i[WIDTH-2:0] & b_i[WIDTH-2:0]) |
               (a_i[WIDTH-2:0] & c_i[WIDTH-2:0]) |
               (b_i[WIDTH-2:0] & c_i[WIDTH-2:0]);
  // carry weighted by 2; the vacated LSB is a free injection point
  assign cy_o = {maj, cin_i};
endmodule

// File: rtl/cmul_csd_net.sv
module cmul_csd_net #(
  parameter int W  = 12,
  parameter int OW = W + 10
) (
  input  logic [W-1:0]  x_i,
  output logic [OW-1:0] s_o,
  output logic [OW-1:0] c_o
);
  logic [OW-1:0] xe;
  logic [OW-1:0] t10, n8, n6, n4, t2, t0;
  logic [OW-1:0] sa, ca, sb, cb, sc, cc;

  assign xe  = {{(OW-W){x_i[W-1]}}, x_i};
  assign t10 = xe << 10;
  assign n8  = ~(xe << 8);
  assign n6  = ~(xe << 6);
  assign n4  = ~(xe << 4);
  assign t2  = xe << 2;
  assign t0  = xe;

  // three inverted terms each need +1: injected as carry-ins of three compressors
  cmul_csa3 #(.WIDTH(OW)) u_a (.a_i(t10), .b_i(n8), .c_i(n6), .cin_i(1'b1), .s_o(sa), .cy_o(ca));
  cmul_csa3 #(.WIDTH(OW)) u_b (.a_i(n4),  .b_i(t2), .c_i(t0), .cin_i(1'b1), .s_o(sb), .cy_o(cb));
  cmul_csa3 #(.WIDTH(OW)) u_c (.a_i(sa),  .b_i(ca), .c_i(sb), .cin_i(1'b1), .s_o(sc), .cy_o(cc));
  cmul_csa3 #(.WIDTH(OW)) u_d (.a_i(sc),  .b_i(cc), .c_i(cb), .cin_i(1'b0), .s_o(s_o), .cy_o(c_o));
endmodule

// File: rtl/cmul_shared_net.sv
module cmul_shared_net #(
  parameter int W  = 12,
  parameter int OW = W + 10
) (
  input  logic [W-1:0]  x_i,
  output logic [OW-1:0] s_o,
  output logic [OW-1:0] c_o
);
  logic [OW-1:0] xe, x16, x4;
  logic [OW-1:0] s1, c1, s1h, c1h, s2, c2;

  assign xe  = {{(OW-W){x_i[W-1]}}, x_i};
  assign x16 = xe << 4;
  assign x4  = xe << 2;

  // stage 1: 21x as a pair
  cmul_csa3 #(.WIDTH(OW)) u_s1 (.a_i(x16), .b_i(x4), .c_i(xe), .cin_i(1'b0), .s_o(s1), .cy_o(c1));

  assign s1h = s1 << 5;
  assign c1h = c1 << 5;

  // stages 2-3: 33 * (s1 + c1)
  cmul_csa3 #(.WIDTH(OW)) u_s2 (.a_i(s1h), .b_i(c1h), .c_i(s1), .cin_i(1'b0), .s_o(s2), .cy_o(c2));
  cmul_csa3 #(.WIDTH(OW)) u_s3 (.a_i(s2),  .b_i(c2),  .c_i(c1), .cin_i(1'b0), .s_o(s_o), .cy_o(c_o));
endmodule

// File: rtl/cmul693_top.sv
module cmul693_top #(
  parameter int                   W    = 12,
  parameter cmul_pkg::cmul_arch_e ARCH = cmul_pkg::CMUL_SHARED,
  localparam int                  OW   = W + int'(cmul_pkg::CMUL_GROWTH)
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          in_vld_i,
  input  logic [W-1:0]  x_i,
  output logic          pair_vld_o,
  output logic [OW-1:0] sum_o,
  output logic [OW-1:0] carry_o,
  output logic          out_vld_o,
  output logic [OW-1:0] prod_o
);
  logic [OW-1:0] net_s, net_c;
  logic [OW-1:0] sum_q, sum_d, car_q, car_d, prod_q, prod_d;
  logic          pvld_q, pvld_d, ovld_q, ovld_d;

  generate
    if (ARCH == cmul_pkg::CMUL_CSD) begin : g_csd
      cmul_csd_net #(.W(W), .OW(OW)) u_net (.x_i(x_i), .s_o(net_s), .c_o(net_c));
    end else begin : g_shared
      cmul_shared_net #(.W(W), .OW(OW)) u_net (.x_i(x_i), .s_o(net_s), .c_o(net_c));
    end
  endgenerate

  always_comb begin
    pvld_d = in_vld_i;
    sum_d  = sum_q;
    car_d  = car_q;
    if (in_vld_i) begin
      sum_d = net_s;
      car_d = net_c;
    end
    ovld_d = pvld_q;
    prod_d = prod_q;
    if (pvld_q) begin
      prod_d = sum_q + car_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pvld_q <= 1'b0;
      sum_q  <= '0;
      car_q  <= '0;
      ovld_q <= 1'b0;
      prod_q <= '0;
    end else begin
      pvld_q <= pvld_d;
      sum_q  <= sum_d;
      car_q  <= car_d;
      ovld_q <= ovld_d;
      prod_q <= prod_d;
    end
  end

  assign pair_vld_o = pvld_q;
  assign sum_o      = sum_q;
  assign carry_o    = car_q;
  assign out_vld_o  = ovld_q;
  assign prod_o     = prod_q;
endmodule

// File: rtl/cmul693_chk.sv
module cmul693_chk #(
  parameter int W  = 12,
  parameter int OW = W + 10
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          in_vld_i,
  input logic [W-1:0]  x_i,
  input logic          pair_vld_o,
  input logic [OW-1:0] sum_o,
  input logic [OW-1:0] carry_o,
  input logic          out_vld_o,
  input logic [OW-1:0] prod_o
);
  logic [OW-1:0] xext, kx, pair_val;
  assign xext     = {{(OW-W){x_i[W-1]}}, x_i};
  assign kx       = xext * OW'(cmul_pkg::CMUL_K);
  assign pair_val = sum_o + carry_o;

  AST_PAIR_VALUE: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_vld_i |=> pair_val == $past(kx)); // R3
  AST_PROD_FROM_PAIR: assert property (@(posedge clk_i) disable iff (!rst_n)
    pair_vld_o |=> prod_o == $past(pair_val)); // R1
  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_vld_o == $past(in_vld_i, 2)); // R2
  AST_PAIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !in_vld_i |=> $stable(sum_o) && $stable(carry_o)); // R4
  AST_PROD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pair_vld_o |=> $stable(prod_o)); // R4
endmodule

bind cmul693_top cmul693_chk #(.W(W), .OW(OW)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .in_vld_i(in_vld_i), .x_i(x_i),
  .pair_vld_o(pair_vld_o), .sum_o(sum_o), .carry_o(carry_o),
  .out_vld_o(out_vld_o), .prod_o(prod_o)
);

// File: tb/cmul693_top_test.sv
module cmul693_top_test;
  localparam int W  = 12;
  localparam int OW = W + 10;

  logic          clk_i = 1'b0;
  logic          rst_n;
  logic          in_vld_i;
  logic [W-1:0]  x_i;
  logic          pair_vld_o, out_vld_o, pvld_b, ovld_b;
  logic [OW-1:0] sum_o, carry_o, prod_o, sum_b, car_b, prod_b;

  int checks = 0;
  int fails  = 0;
  logic [OW-1:0] pq[$];
  logic [OW-1:0] oq[$];
  logic          h1 = 1'b0, h2 = 1'b0;
  logic [OW-1:0] last_prod = '0, last_sum = '0, last_car = '0;
  logic          done = 1'b0;

  always #5 clk_i = ~clk_i;

  cmul693_top #(.W(W), .ARCH(cmul_pkg::CMUL_SHARED)) uut (
    .clk_i(clk_i), .rst_n(rst_n), .in_vld_i(in_vld_i), .x_i(x_i),
    .pair_vld_o(pair_vld_o), .sum_o(sum_o), .carry_o(carry_o),
    .out_vld_o(out_vld_o), .prod_o(prod_o));

  cmul693_top #(.W(W), .ARCH(cmul_pkg::CMUL_CSD)) uut_csd (
    .clk_i(clk_i), .rst_n(rst_n), .in_vld_i(in_vld_i), .x_i(x_i),
    .pair_vld_o(pvld_b), .sum_o(sum_b), .carry_o(car_b),
    .out_vld_o(ovld_b), .prod_o(prod_b));

  task automatic check(input logic ok, input string req, input logic [OW-1:0] act,
                       input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int v);
    logic [OW-1:0] e;
    @(posedge clk_i); #2;
    x_i      = W'(v);
    in_vld_i = 1'b1;
    e        = OW'(v * 693);
    pq.push_back(e);
    oq.push_back(e);
  endtask

  task automatic idle(input int v);
    @(posedge clk_i); #2;
    x_i      = W'(v);
    in_vld_i = 1'b0;
  endtask

  // monitor: scoreboard and port-level rules, sampled on the falling edge
  always @(negedge clk_i) begin
    logic [OW-1:0] e;
    if (!rst_n) begin
      check(!pair_vld_o && !out_vld_o && sum_o == '0 && carry_o == '0 && prod_o == '0,
            "R6 reset outputs", prod_o, '0);
      check(!pvld_b && !ovld_b && prod_b == '0, "R6 reset outputs csd", prod_b, '0);
    end else begin
      check(pair_vld_o == h1, "R2 pair latency", OW'(pair_vld_o), OW'(h1));
      check(out_vld_o == h2, "R2 product latency", OW'(out_vld_o), OW'(h2));
      if (pair_vld_o) begin
        e = (pq.size() != 0) ? pq.pop_front() : '1;
        check(OW'(sum_o + carry_o) == e, "R3 pair value", OW'(sum_o + carry_o), e);
      end else begin
        check(sum_o == last_sum && carry_o == last_car, "R4 pair hold", sum_o, last_sum);
      end
      if (out_vld_o) begin
        e = (oq.size() != 0) ? oq.pop_front() : '1;
        check(prod_o == e, "R1 product", prod_o, e);
        check(prod_b == e, "R5 csd product equals expected", prod_b, e);
      end else begin
        check(prod_o == last_prod, "R4 product hold", prod_o, last_prod);
      end
      last_sum  = sum_o;
      last_car  = carry_o;
      last_prod = prod_o;
      h2 = h1;
      h1 = in_vld_i;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_vld_i = 1'b0;
    x_i      = '0;
    repeat (3) @(posedge clk_i);
    #2 rst_n = 1'b1;
    idle(0);
    // a lone sample between idle cycles, then the full sweep with gaps
    send(-2048);
    idle(1234);
    idle(77);
    for (int v = -(1 << (W-1)); v < (1 << (W-1)); v++) begin
      send(v);
      if (v % 97 == 0) idle(v ^ 12'h5a5);
    end
    send(2047);
    send(-1);
    repeat (6) idle(3);
    @(negedge clk_i);
    check(pq.size() == 0 && oq.size() == 0, "R1 scoreboard drained",
          OW'(pq.size() + oq.size()), '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule